// File: doc/BRIEF.md
# Digitally Controlled Clock Generator

This block models a digitally controlled oscillator in synthesizable logic. A fast reference clock stands in for one stage delay. A tick counter forms an odd base period whose length the top three bits of an 8-bit stage code select. A power-of-two divider then stretches that base period to give the internal clock output. A one-cycle strobe marks every level change of the output, so logic in the reference domain can follow the generated clock without an edge detector of its own.

The stage and divider codes may change at any time. The block samples them only when both the base period and the divider wrap, so a pulse already in progress is never cut short. After reset the output stays low for one whole selected period and then starts toggling. The low five stage bits, which would select fractional dithering in an analog oscillator, have no effect here.

Top module: `dco_clkgen`

## Requirements
- R1: With divider code 0, the output period is N = 17 + 2*S reference cycles, where S is stage_code[7:5]. S = 0 gives 17 and S = 7 gives 31.
- R2: The output period is N * 2^D, where D is div_code. Raising D by one doubles the period.
- R3: Divider codes 10 to 15 behave exactly like code 9, which is a divide by 512.
- R4: With divider code 0, each period is high for (N+1)/2 cycles, then low for (N-1)/2 cycles.
- R5: With a divider code of 1 or more, each period is high for exactly half the period, then low for the other half.
- R6: stage_code[4:0] has no effect on the output.
- R7: While reset is high, iclk_out and iclk_edge are 0. The first rising edge of iclk_out comes P+1 cycles after the first clock edge with reset low, where P is the period set by the codes present during reset.
- R8: New codes take effect only at the end of a full divided period. A change made during a period leaves the rest of that period unchanged, so the next rising edge comes one old low-phase length after the last falling edge.
- R9: iclk_edge is high for exactly those cycles in which iclk_out differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle equals one stage delay |
| rst | input | 1 | Synchronous active-high reset; also loads the codes |
| stage_code | input | 8 | Stage code; bits 7:5 select the base period |
| div_code | input | 4 | Power-of-two divider code, saturating at 9 |
| iclk_out | output | 1 | Generated internal clock |
| iclk_edge | output | 1 | One-cycle strobe on each change of iclk_out |

## Verification
The bench runs the generator through a sequence of code pairs and measures the spacing of every output edge. Stepping the stage code at divider 0 checks the odd base periods and the lopsided duty cycle. Pairs that differ only in the low stage bits must give the same spacing. Successive divider codes must double the high and low phases, and codes 9, 13 and 15 must give the full 512 multiple. Every change of codes is made while the output is high, so the first rising edge after it shows whether the old period was allowed to finish before the new codes took effect.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    localparam int STAGE_W   = 8;
    localparam int DIV_W     = 4;
    localparam int SEL_W     = 3;
    localparam int BASE_MIN  = 17;
    localparam int BASE_STEP = 2;
    localparam int DIV_MAX   = 9;

    localparam int BASE_MAX  = BASE_MIN + BASE_STEP * ((1 << SEL_W) - 1);
    localparam int TICK_W    = $clog2(BASE_MAX + 1);
    localparam int SCALE_W   = $clog2(DIV_MAX + 1);
    localparam int CYC_W     = DIV_MAX;

    // Latched generator settings, applied for one full divided period.
    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [SCALE_W-1:0] scale;
    } dcg_cfg_t;

    // Base period length in reference ticks for a stage selection.
    function automatic logic [TICK_W-1:0] base_ticks(input logic [SEL_W-1:0] sel);
        return TICK_W'(BASE_MIN + BASE_STEP * int'(sel));
    endfunction

    // Number of ticks the base clock stays high (odd length rounds up).
    function automatic logic [TICK_W-1:0] high_ticks(input logic [TICK_W-1:0] n);
        logic [TICK_W:0] wide;
        wide = {1'b0, n} + 1'b1;
        return wide[TICK_W:1];
    endfunction

    // Divider codes above the maximum behave as the maximum.
    function automatic logic [SCALE_W-1:0] sat_scale(input logic [DIV_W-1:0] code);
        if (int'(code) > DIV_MAX)
            return SCALE_W'(DIV_MAX);
        return SCALE_W'(code);
    endfunction

endpackage

// File: rtl/dcg_cfg_reg.sv
module dcg_cfg_reg
    import dcg_pkg::*;
#(
    parameter int STG_W = STAGE_W,
    parameter int DV_W  = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STG_W-1:0]  stage_in,
    input  logic [DV_W-1:0]   div_in,
    output dcg_cfg_t          cfg_q
);

    dcg_cfg_t cfg_d;

    always_comb begin
        cfg_d.sel   = stage_in[STG_W-1 -: SEL_W];
        cfg_d.scale = sat_scale(DIV_W'(div_in));
    end

    always_ff @(posedge clk) begin
        if (rst || load)
            cfg_q <= cfg_d;
    end

endmodule

// File: rtl/dcg_tick_timer.sv
module dcg_tick_timer
    import dcg_pkg::*;
#(
    parameter int TW = TICK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] n_ticks,
    output logic [TW-1:0] tick_cnt,
    output logic          last_tick,
    output logic          early_half
);

    logic [TW-1:0] hi_len;

    always_comb begin
        hi_len     = TW'(high_ticks(TICK_W'(n_ticks)));
        last_tick  = (tick_cnt == n_ticks - 1'b1);
        early_half = (tick_cnt < hi_len);
    end

    always_ff @(posedge clk) begin
        if (rst)
            tick_cnt <= '0;
        else if (last_tick)
            tick_cnt <= '0;
        else
            tick_cnt <= tick_cnt + 1'b1;
    end

endmodule

// File: rtl/dcg_pow2_div.sv
module dcg_pow2_div
    import dcg_pkg::*;
#(
    parameter int CW = CYC_W,
    parameter int SW = SCALE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [SW-1:0] scale,
    output logic          wrap,
    output logic          first_half
);

    logic [CW-1:0] base_cnt;
    logic [CW-1:0] limit;
    logic [SW-1:0] msb_idx;
    logic [CW-1:0] ones;

    always_comb begin
        ones       = '1;
        limit      = ~(ones << scale);
        msb_idx    = scale - 1'b1;
        wrap       = step && (base_cnt == limit);
        first_half = ((base_cnt >> msb_idx) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            base_cnt <= '0;
        else if (step)
            base_cnt <= wrap ? '0 : base_cnt + 1'b1;
    end

endmodule

// File: rtl/dco_clkgen.sv
module dco_clkgen
    import dcg_pkg::*;
#(
    parameter int STG_W = STAGE_W,
    parameter int DV_W  = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [STG_W-1:0] stage_code,
    input  logic [DV_W-1:0]  div_code,
    output logic             iclk_out,
    output logic             iclk_edge
);

    dcg_cfg_t         cfg_q;
    logic [TICK_W-1:0] n_ticks;
    logic [TICK_W-1:0] tick_cnt;
    logic             last_tick;
    logic             early_half;
    logic             wrap;
    logic             first_half;
    logic             run_q;
    logic             out_next;

    dcg_cfg_reg #(.STG_W(STG_W), .DV_W(DV_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (wrap),
        .stage_in (stage_code),
        .div_in   (div_code),
        .cfg_q    (cfg_q)
    );

    assign n_ticks = base_ticks(cfg_q.sel);

    dcg_tick_timer #(.TW(TICK_W)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .n_ticks    (n_ticks),
        .tick_cnt   (tick_cnt),
        .last_tick  (last_tick),
        .early_half (early_half)
    );

    dcg_pow2_div #(.CW(CYC_W), .SW(SCALE_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .step       (last_tick),
        .scale      (cfg_q.scale),
        .wrap       (wrap),
        .first_half (first_half)
    );

    // High phase comes first in each period; the whole first period after
    // reset is held low while run_q is clear.
    always_comb begin
        if (cfg_q.scale == '0)
            out_next = run_q && early_half;
        else
            out_next = run_q && first_half;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            iclk_out  <= 1'b0;
            iclk_edge <= 1'b0;
        end else begin
            if (wrap)
                run_q <= 1'b1;
            iclk_out  <= out_next;
            iclk_edge <= (out_next != iclk_out);
        end
    end

endmodule

// File: rtl/dcg_checker.sv
module dcg_checker
    import dcg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iclk_out,
    input logic              iclk_edge,
    input logic              run_q,
    input logic              wrap,
    input dcg_cfg_t          cfg_q,
    input logic [TICK_W-1:0] tick_cnt,
    input logic [TICK_W-1:0] n_ticks
);

    a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (rst)
        (iclk_out != $past(iclk_out)) |-> iclk_edge);

    a_r9_strobe_only_change: assert property (@(posedge clk) disable iff (rst)
        iclk_edge |-> (iclk_out != $past(iclk_out)));

    a_r7_quiet_before_run: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !iclk_out);

    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(wrap) && !$past(rst)) |-> $stable(cfg_q));

    a_r1_tick_bound: assert property (@(posedge clk) disable iff (rst)
        tick_cnt < n_ticks);

    a_r3_scale_cap: assert property (@(posedge clk) disable iff (rst)
        int'(cfg_q.scale) <= DIV_MAX);

    a_r4_min_high: assert property (@(posedge clk) disable iff (rst)
        $rose(iclk_out) |=> iclk_out);

endmodule

bind dco_clkgen dcg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .iclk_out  (iclk_out),
    .iclk_edge (iclk_edge),
    .run_q     (run_q),
    .wrap      (wrap),
    .cfg_q     (cfg_q),
    .tick_cnt  (tick_cnt),
    .n_ticks   (n_ticks)
);

// File: tb/dco_clkgen_test.sv
module dco_clkgen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] stage_code = 8'h00;
    logic [3:0] div_code = 4'h0;
    logic       iclk_out;
    logic       iclk_edge;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int last_edge_cyc = 0;
    int prev_low = 0;
    logic prev_out = 1'b0;

    int    exp_delta[$];
    bit    exp_level[$];
    string exp_tag[$];

    always #5 clk = ~clk;

    dco_clkgen uut (
        .clk        (clk),
        .rst        (rst),
        .stage_code (stage_code),
        .div_code   (div_code),
        .iclk_out   (iclk_out),
        .iclk_edge  (iclk_edge)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Monitor: pops an expected edge each time the output changes level.
    always @(negedge clk) begin
        if (!rst) begin
            if (iclk_out != prev_out) begin
                vectors++;
                if (!iclk_edge) begin
                    miscompares++;
                    $display("FAIL R9: strobe=%0b expected 1 at cycle %0d", iclk_edge, cyc);
                end
                vectors++;
                if (exp_delta.size() == 0) begin
                    miscompares++;
                    $display("FAIL R2: unexpected edge level=%0b at cycle %0d, expected none", iclk_out, cyc);
                end else begin
                    int    d;
                    bit    lv;
                    string tg;
                    d  = exp_delta.pop_front();
                    lv = exp_level.pop_front();
                    tg = exp_tag.pop_front();
                    if (iclk_out != lv || (cyc - last_edge_cyc) != d) begin
                        miscompares++;
                        $display("FAIL %s: level=%0b spacing=%0d, expected level=%0b spacing=%0d",
                                 tg, iclk_out, cyc - last_edge_cyc, lv, d);
                    end
                end
                last_edge_cyc = cyc;
            end else if (iclk_edge) begin
                vectors++;
                miscompares++;
                $display("FAIL R9: strobe=1 expected 0 with steady output at cycle %0d", cyc);
            end
            prev_out = iclk_out;
        end
    end

    // Driver: applies a code pair and queues the edges it must produce.
    task automatic apply_seg(input logic [7:0] s, input logic [3:0] d,
                             input int nper, input string tag, input bit first);
        int n, ds, p, hi, lo;
        n  = 17 + 2 * int'(s[7:5]);
        ds = (int'(d) > 9) ? 9 : int'(d);
        p  = n << ds;
        hi = (ds == 0) ? (n + 1) / 2 : p / 2;
        lo = p - hi;
        stage_code = s;
        div_code   = d;
        for (int k = 0; k < nper; k++) begin
            if (k == 0 && first) begin
                exp_delta.push_back(p + 1); exp_tag.push_back("R7");
            end else if (k == 0) begin
                exp_delta.push_back(prev_low); exp_tag.push_back("R8");
            end else begin
                exp_delta.push_back(lo); exp_tag.push_back(tag);
            end
            exp_level.push_back(1'b1);
            exp_delta.push_back(hi);
            exp_level.push_back(1'b0);
            exp_tag.push_back((ds == 0) ? "R4" : "R5");
        end
        prev_low = lo;
    endtask

    task automatic wait_rises(input int nper);
        repeat (nper) @(posedge iclk_out);
        #1;
    endtask

    task automatic check_reset_state;
        @(negedge clk);
        vectors++;
        if (iclk_out !== 1'b0 || iclk_edge !== 1'b0) begin
            miscompares++;
            $display("FAIL R7: out=%0b strobe=%0b during reset, expected 0 0", iclk_out, iclk_edge);
        end
    endtask

    initial begin
        apply_seg(8'h00, 4'd0, 3, "R1", 1'b1);
        repeat (3) check_reset_state();
        rst = 1'b0;
        wait_rises(3);
        apply_seg(8'hE0, 4'd0, 3, "R1", 1'b0);  wait_rises(3);
        apply_seg(8'h3F, 4'd1, 2, "R6", 1'b0);  wait_rises(2);
        apply_seg(8'h20, 4'd1, 2, "R6", 1'b0);  wait_rises(2);
        apply_seg(8'h40, 4'd3, 2, "R2", 1'b0);  wait_rises(2);
        apply_seg(8'h40, 4'd4, 2, "R2", 1'b0);  wait_rises(2);
        apply_seg(8'h7B, 4'd2, 2, "R5", 1'b0);  wait_rises(2);
        apply_seg(8'h00, 4'd9, 1, "R3", 1'b0);  wait_rises(1);
        apply_seg(8'h00, 4'd13, 1, "R3", 1'b0); wait_rises(1);
        apply_seg(8'hE0, 4'd15, 1, "R3", 1'b0); wait_rises(1);
        apply_seg(8'hA0, 4'd0, 2, "R4", 1'b0);
        while (exp_delta.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        miscompares++;
        $display("FAIL R2: watchdog expired with %0d edges pending, expected 0", exp_delta.size());
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule